// File: doc/BRIEF.md
# Ordered Request/Completion Tracking Checker

This block is a synthesizable monitor for a handshake in which a one-bit request pulse must be answered later by a one-bit completion pulse on the same clock. It matches completions to requests first-in, first-out. Each completion retires exactly one pending request, and always the oldest one. A single completion therefore can never close several overlapping requests. Every pending request keeps its own age counter. A request must be retired between 1 and 10 cycles after it was issued.

The checker stores at most 8 pending requests in a ring of age counters. It raises four sticky error flags and reports the number of pending requests. The flags cover too many pending requests, a completion with nothing pending, a pending request that outlives its window, and requests still pending when the end-of-test strobe is raised. The checker is meant to sit beside a design or a bus port in simulation or on an FPGA. It drives nothing back into the logic it watches.

Top module: `req_cpl_order_checker`

## Requirements
- R1: A synchronous active-high reset clears all four error flags, the pending count and every queued entry. These values show on the outputs on the cycle after the reset edge.
- R2: A clock edge with a request and no completion raises the count by one. A completion alone lowers the count by one, provided the count is above zero.
- R3: A completion retires the oldest pending request. A completion on the same edge as a request never retires that new request.
- R4: A completion that comes exactly 1 cycle, or exactly 10 cycles, after the oldest pending request raises no error.
- R5: Suppose that, at an edge, the oldest pending request is 10 cycles old and no completion is present, or that it is already older than 10 cycles. Then the timeout flag is set.
- R6: A completion that arrives while the count is zero sets the stray flag. A request on that same edge is still queued, so the count becomes 1.
- R7: A request that arrives with 8 requests pending and no completion sets the overflow flag. That request is discarded and the count stays at 8.
- R8: With 8 requests pending, a request and a completion on the same edge set no flag, and the count stays at 8.
- R9: The end-of-test strobe sets the end-of-test flag if the count is non-zero at that edge. When the count is zero, the strobe has no effect.
- R10: Every error flag, once set, stays set until reset.
- R11: The flags and the count are registered. They change only in the cycle after the edge that samples the inputs causing the change.
- R12: A pending entry is never retired with an age below 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request pulse, one per cycle |
| cpl_i | input | 1 | Completion pulse, retires the oldest pending request |
| eot_i | input | 1 | End-of-test strobe |
| err_overflow_o | output | 1 | Sticky: a request arrived with the queue full |
| err_stray_o | output | 1 | Sticky: a completion arrived with nothing pending |
| err_timeout_o | output | 1 | Sticky: the oldest request passed its window |
| err_eot_o | output | 1 | Sticky: requests pending at end of test |
| outstanding_o | output | CNT_W (4) | Current number of pending requests |

## Verification
The bench makes a request and a completion fall on the same edge on purpose in three cases: with one entry pending, with the queue empty, and with the queue full. In each case it judges the count and the overflow and stray flags against its own queue model. The model holds back the request's enqueue until the completion has retired the older entry. A second targeted case puts a completion on the same edge on which the oldest entry reaches age 10, and the bench expects no timeout. A randomized phase then compares every output against the model on every cycle.

// File: rtl/rco_pkg.sv
package rco_pkg;

  // index of each error in the sticky flag vector
  localparam int ERR_OVF  = 0;
  localparam int ERR_STRY = 1;
  localparam int ERR_TMO  = 2;
  localparam int ERR_EOT  = 3;
  localparam int ERR_N    = 4;

  function automatic int width_for(input int max_value);
    int w;
    w = 1;
    while ((1 << w) <= max_value) w++;
    return w;
  endfunction

endpackage

// File: rtl/rco_age_slot.sv
// One queue entry: an age counter that saturates one step past the window.
module rco_age_slot #(
  parameter int AGE_W   = 4,
  parameter int SAT_AGE = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  output logic [AGE_W-1:0] age
);
  localparam logic [AGE_W-1:0] SAT_V = AGE_W'(SAT_AGE);
  localparam logic [AGE_W-1:0] ONE_V = AGE_W'(1);

  // Loaded with 1: the earliest edge that may retire it sees age 1.
  always_ff @(posedge clk) begin
    if (rst)
      age <= '0;
    else if (load)
      age <= ONE_V;
    else if (age != SAT_V)
      age <= age + ONE_V;
  end
endmodule

// File: rtl/rco_ring_ctrl.sv
// Ring pointers and occupancy; decides push, pop and the two queue-level errors.
module rco_ring_ctrl #(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             cpl,
  output logic             push,
  output logic             pop,
  output logic             ovf_evt,
  output logic             stray_evt,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] FULL_V = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] ONE_P  = PTR_W'(1);

  logic empty, full;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_P) ? '0 : p + ONE_P;
  endfunction

  always_comb begin
    empty     = (count == '0);
    full      = (count == FULL_V);
    pop       = cpl && !empty;
    // a completion on the same edge frees one slot for the new request
    push      = req && (!full || pop);
    ovf_evt   = req && !push;
    stray_evt = cpl && empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + ONE_C;
        2'b01:   count <= count - ONE_C;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rco_err_latch.sv
// Sticky error flags, cleared only by reset.
module rco_err_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_evt,
  output logic [N-1:0] flags
);
  always_ff @(posedge clk) begin
    if (rst)
      flags <= '0;
    else
      flags <= flags | set_evt;
  end
endmodule

// File: rtl/req_cpl_order_checker.sv
module req_cpl_order_checker
  import rco_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int MIN_LAT = 1,
  parameter int MAX_LAT = 10,
  parameter int CNT_W   = width_for(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             cpl_i,
  input  logic             eot_i,
  output logic             err_overflow_o,
  output logic             err_stray_o,
  output logic             err_timeout_o,
  output logic             err_eot_o,
  output logic [CNT_W-1:0] outstanding_o
);
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SAT_AGE = MAX_LAT + 1;
  localparam int AGE_W   = width_for(SAT_AGE);
  localparam logic [AGE_W-1:0] MAX_V = AGE_W'(MAX_LAT);

  logic             push, pop, ovf_evt, stray_evt, tmo_evt, eot_evt;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic [AGE_W-1:0] ages [DEPTH];
  logic [AGE_W-1:0] head_age;
  logic [ERR_N-1:0] set_evt, flags;

  rco_ring_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ring (
    .clk(clk), .rst(rst), .req(req_i), .cpl(cpl_i),
    .push(push), .pop(pop), .ovf_evt(ovf_evt), .stray_evt(stray_evt),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic load_i;
    assign load_i = push && (wr_ptr == PTR_W'(i));
    rco_age_slot #(.AGE_W(AGE_W), .SAT_AGE(SAT_AGE)) u_slot (
      .clk(clk), .rst(rst), .load(load_i), .age(ages[i])
    );
  end

  always_comb begin
    head_age = ages[rd_ptr];
    // only the oldest entry can expire first; younger ones are strictly younger
    tmo_evt  = (count != '0) &&
               ((head_age > MAX_V) || ((head_age == MAX_V) && !cpl_i));
    eot_evt  = eot_i && (count != '0);
    set_evt  = '0;
    set_evt[ERR_OVF]  = ovf_evt;
    set_evt[ERR_STRY] = stray_evt;
    set_evt[ERR_TMO]  = tmo_evt;
    set_evt[ERR_EOT]  = eot_evt;
  end

  rco_err_latch #(.N(ERR_N)) u_err (
    .clk(clk), .rst(rst), .set_evt(set_evt), .flags(flags)
  );

  assign err_overflow_o = flags[ERR_OVF];
  assign err_stray_o    = flags[ERR_STRY];
  assign err_timeout_o  = flags[ERR_TMO];
  assign err_eot_o      = flags[ERR_EOT];
  assign outstanding_o  = count;
endmodule

// File: rtl/rco_checker.sv
module rco_checker #(
  parameter int DEPTH   = 8,
  parameter int MIN_LAT = 1,
  parameter int CNT_W   = 4,
  parameter int AGE_W   = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_i,
  input logic             cpl_i,
  input logic             eot_i,
  input logic             err_overflow_o,
  input logic             err_stray_o,
  input logic             err_timeout_o,
  input logic             err_eot_o,
  input logic [CNT_W-1:0] outstanding_o,
  input logic             pop,
  input logic [AGE_W-1:0] head_age
);
  localparam logic [CNT_W-1:0] FULL_V = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);
  localparam logic [AGE_W-1:0] MIN_V  = AGE_W'(MIN_LAT);

  a_r2_req_increments: assert property (@(posedge clk) disable iff (rst)
    (req_i && !cpl_i && outstanding_o != FULL_V) |=> outstanding_o == $past(outstanding_o) + ONE_C);

  a_r2_cpl_decrements: assert property (@(posedge clk) disable iff (rst)
    (cpl_i && !req_i && outstanding_o != '0) |=> outstanding_o == $past(outstanding_o) - ONE_C);

  a_r6_stray_flagged: assert property (@(posedge clk) disable iff (rst)
    (cpl_i && outstanding_o == '0) |=> err_stray_o);

  a_r7_overflow_flagged: assert property (@(posedge clk) disable iff (rst)
    (req_i && !cpl_i && outstanding_o == FULL_V) |=> (err_overflow_o && outstanding_o == FULL_V));

  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    outstanding_o <= FULL_V);

  a_r9_eot_flagged: assert property (@(posedge clk) disable iff (rst)
    (eot_i && outstanding_o != '0) |=> err_eot_o);

  a_r10_sticky_timeout: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(err_timeout_o)) |-> err_timeout_o);

  a_r10_sticky_overflow: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(err_overflow_o)) |-> err_overflow_o);

  a_r12_no_early_retire: assert property (@(posedge clk) disable iff (rst)
    pop |-> head_age >= MIN_V);
endmodule

bind req_cpl_order_checker rco_checker #(
  .DEPTH(DEPTH), .MIN_LAT(MIN_LAT), .CNT_W(CNT_W), .AGE_W(AGE_W)
) u_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .cpl_i(cpl_i), .eot_i(eot_i),
  .err_overflow_o(err_overflow_o), .err_stray_o(err_stray_o),
  .err_timeout_o(err_timeout_o), .err_eot_o(err_eot_o),
  .outstanding_o(outstanding_o), .pop(pop), .head_age(head_age)
);

// File: tb/req_cpl_order_checker_test.sv
`timescale 1ns/1ps
module req_cpl_order_checker_test;
  localparam int DEPTH = 8;
  localparam int MAXL  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, cpl = 1'b0, eot = 1'b0;
  logic e_ovf, e_stray, e_tmo, e_eot;
  logic [3:0] cnt;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  int q[$];
  int cyc = 0;
  bit m_ovf, m_stray, m_tmo, m_eot;

  always #4 clk = ~clk;

  req_cpl_order_checker uut (
    .clk(clk), .rst(rst), .req_i(req), .cpl_i(cpl), .eot_i(eot),
    .err_overflow_o(e_ovf), .err_stray_o(e_stray), .err_timeout_o(e_tmo),
    .err_eot_o(e_eot), .outstanding_o(cnt)
  );

  task automatic model_edge(input bit r, input bit c, input bit e);
    int age;
    bit popped;
    cyc++;
    if (rst) begin
      q.delete();
      m_ovf = 0; m_stray = 0; m_tmo = 0; m_eot = 0;
      return;
    end
    popped = 0;
    if (e && q.size() != 0) m_eot = 1;
    if (q.size() != 0) begin
      age = cyc - q[0];
      if (age > MAXL || (age == MAXL && !c)) m_tmo = 1;
    end
    if (c) begin
      if (q.size() == 0) m_stray = 1;
      else begin void'(q.pop_front()); popped = 1; end
    end
    if (r) begin
      if (q.size() >= DEPTH) m_ovf = 1;
      else q.push_back(cyc);
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (cnt !== 4'(q.size()) || e_ovf !== m_ovf || e_stray !== m_stray ||
        e_tmo !== m_tmo || e_eot !== m_eot) begin
      fails++;
      $display("FAIL %s: got cnt=%0d ovf=%0b stray=%0b tmo=%0b eot=%0b, expected cnt=%0d ovf=%0b stray=%0b tmo=%0b eot=%0b",
               tag, cnt, e_ovf, e_stray, e_tmo, e_eot,
               q.size(), m_ovf, m_stray, m_tmo, m_eot);
    end
  endtask

  task automatic step(input bit r, input bit c, input bit e, input string tag);
    req = r; cpl = c; eot = e;
    @(posedge clk);
    model_edge(r, c, e);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(0, 0, 0, "R1 reset");
    step(0, 0, 0, "R1 reset");
    rst = 1'b0;
    step(0, 0, 0, "R1 after reset");
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, tag);
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // R2 / R4: minimum latency
    step(1, 0, 0, "R2 req raises count");
    step(0, 1, 0, "R4 completion at age 1");
    idle(2, "R11 quiet");

    // R4: maximum latency, completion on the same edge the entry hits age 10
    step(1, 0, 0, "R2 req");
    idle(9, "R4 waiting");
    step(0, 1, 0, "R4 completion at age 10");
    idle(2, "R5 no timeout after on-time completion");

    // R3: ordered matching; youngest-first matching would time out the first
    step(1, 0, 0, "R3 first req");
    idle(4, "R3 gap");
    step(1, 0, 0, "R3 second req");
    idle(3, "R3 gap");
    step(0, 1, 0, "R3 retires oldest");
    idle(4, "R3 gap");
    step(0, 1, 0, "R3 retires second");

    // R2 / R3: coincident request and completion with one pending
    step(1, 0, 0, "R2 req");
    step(1, 1, 0, "R2 coincident keeps count");
    step(0, 1, 0, "R3 new req retired later");
    step(0, 0, 1, "R9 eot with zero count ignored");

    // R5: timeout
    step(1, 0, 0, "R5 req");
    idle(12, "R5 timeout window");
    step(0, 1, 0, "R5 late completion");
    idle(3, "R10 timeout sticky");
    do_reset();

    // R6: stray completion plus coincident request is queued
    step(1, 1, 0, "R6 stray with coincident req");
    step(0, 1, 0, "R3 retire the queued req");
    step(0, 1, 0, "R6 stray alone");
    idle(3, "R10 stray sticky");
    do_reset();

    // R8 / R7: full queue
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, "R2 fill");
    step(1, 1, 0, "R8 full with coincident req and cpl");
    step(1, 0, 0, "R7 overflow");
    step(0, 0, 1, "R9 eot with pending");
    idle(2, "R10 sticky");
    do_reset();

    // randomized mix, compared each cycle
    for (int n = 0; n < 3000; n++) begin
      if (n % 250 == 249) do_reset();
      else step(($urandom % 100) < 40, ($urandom % 100) < 38,
                ($urandom % 100) < 2, "R2 R3 R5 random mix");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule